// File: doc/BRIEF.md
# Windowed Watchdog Violation Status Register

This block keeps a record of windowed watchdog violations in one 32-bit status word that software can read and clear. The watchdog core sends it one-cycle pulses for three causes: the counter ran past the end of the window, a key arrived before the window opened, or a wrong key or key order was written. Each pulse sets a sticky flag for its cause and also sets a summary flag. The summary flag drives the non-maskable interrupt request.

Software reads the word through a simple bus port. Read data is registered, and a read does not change any flag. Software clears flags with write-1-to-clear writes, and these writes count only when the privilege qualifier is high. Writing 1 to the summary bit clears every flag at once and releases the interrupt.

There are two resets. The power-on reset clears everything. The soft reset clears only the read-data register, so the violation history is still there after it.

Top module: `wdog_viol_status`

## Requirements
- R1: Bits 31 to 6 and bit 0 of the status word always read as 0, and writing 1 to any of them changes nothing.
- R2: Field positions: bit 5 is the summary, bit 4 is end-of-window expiry, bit 3 is early key (key before the window opened), bit 2 is wrong key or key order, and bit 1 is the expiry mirror.
- R3: Bit 1 always reads the same value as bit 4. A privileged write of 1 to either bit clears the expiry flag.
- R4: A privileged write of 1 to bit 4, 3 or 2 clears that flag only. Writing 0 to a flag leaves it unchanged.
- R5: A write with `priv` low changes no flag.
- R6: A privileged write of 1 to bit 5 clears the summary flag and all cause flags in the same cycle.
- R7: `nmi_req` is high exactly when the summary flag is set. It falls on the clock edge that takes a summary clear, unless a new event arrives in that same cycle.
- R8: Only `por_n` low clears the flags. A `soft_rst` pulse leaves every flag unchanged.
- R9: An event pulse sets its own cause flag and the summary flag at the next edge. If a clear of that flag arrives in the same cycle, the set wins.
- R10: When `rd_en` is high, `rdata` shows the word as it stood in that cycle, from the next edge until the next read. A read changes no flag. `soft_rst` and `por_n` clear `rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears flags and read data |
| soft_rst | input | 1 | Soft reset, synchronous, active high; clears read data only |
| wr_en | input | 1 | Write strobe for the status word |
| priv | input | 1 | Privilege qualifier; writes count only when high |
| wdata | input | 32 | Write data, 1 clears the matching flag |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| ev_expire | input | 1 | Pulse: counter ran past window end |
| ev_early_key | input | 1 | Pulse: key written before window opened |
| ev_bad_key | input | 1 | Pulse: wrong key or key order |
| nmi_req | output | 1 | Non-maskable interrupt request, equal to the summary flag |

## Verification
The bench sweeps every starting flag set together with every event combination, every write mask over bits 5 to 1, both privilege levels, and reserved bits written both all-zero and all-one. For each case it compares the word read back and the interrupt level with values it computes itself.

This sweep catches four kinds of bug:
- A design that lets the clear win over a same-cycle event would lose a violation.
- A design that treats bit 5 as clearing only itself would leave cause flags set.
- A design that forgets the bit 1 alias would let bit 4 and bit 1 disagree.
- A design that ignores `priv` would let unprivileged writes clear flags.

Directed steps check that a soft reset preserves the flags and blanks the read data, and that the power-on reset wipes the flags.

// File: rtl/wdsts_pkg.sv
package wdsts_pkg;

    localparam int unsigned WORD_DEF  = 32;
    localparam int unsigned NUM_CAUSE = 3;

    // Field positions decoded by software
    localparam int unsigned POS_SUM   = 5;
    localparam int unsigned POS_END   = 4;
    localparam int unsigned POS_EARLY = 3;
    localparam int unsigned POS_KEY   = 2;
    localparam int unsigned POS_EXP   = 1;

    // cause[0] = end-of-window expiry, cause[1] = early key, cause[2] = bad key
    typedef struct packed {
        logic                 summary;
        logic [NUM_CAUSE-1:0] cause;
    } flags_t;

endpackage

// File: rtl/wdsts_flags.sv
module wdsts_flags
    import wdsts_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_DEF
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 wr_en,
    input  logic                 priv,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [NUM_CAUSE-1:0] cause_ev,
    output flags_t               flags_q
);

    logic                 wr_ok;
    logic                 clr_all;
    logic [NUM_CAUSE-1:0] clr_hit;
    flags_t               st_d;
    flags_t               st_q;

    assign wr_ok   = wr_en & priv;
    assign clr_all = wr_ok & wdata[POS_SUM];

    // Cause i is cleared by its own bit; expiry also by its mirror bit
    for (genvar gi = 0; gi < NUM_CAUSE; gi++) begin : g_cause
        localparam int unsigned POS = POS_END - gi;
        if (gi == 0) begin : g_exp
            assign clr_hit[gi] = clr_all | (wr_ok & (wdata[POS] | wdata[POS_EXP]));
        end else begin : g_oth
            assign clr_hit[gi] = clr_all | (wr_ok & wdata[POS]);
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.cause   = cause_ev | (st_q.cause & ~clr_hit);
        st_d.summary = (|cause_ev) | (st_q.summary & ~clr_all);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!por_n)
        (|cause_ev) |=> (flags_q.summary &&
                         ((flags_q.cause & $past(cause_ev)) == $past(cause_ev)))); // R9

    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && priv && wdata[POS_SUM] && !(|cause_ev)) |=> (flags_q == '0)); // R6

    AST_NO_DROP: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_en && priv) |=> (((flags_q.cause & $past(flags_q.cause)) == $past(flags_q.cause))
                              && (!$past(flags_q.summary) || flags_q.summary))); // R5

endmodule

// File: rtl/wdsts_rdport.sv
module wdsts_rdport
    import wdsts_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_DEF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              rd_en,
    input  flags_t            flags,
    output logic [WORD_W-1:0] rdata_q
);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] rd_d;

    always_comb begin
        word            = '0;
        word[POS_SUM]   = flags.summary;
        word[POS_END]   = flags.cause[0];
        word[POS_EARLY] = flags.cause[1];
        word[POS_KEY]   = flags.cause[2];
        word[POS_EXP]   = flags.cause[0];
        if (soft_rst)   rd_d = '0;
        else if (rd_en) rd_d = word;
        else            rd_d = rdata_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rdata_q <= '0;
        else        rdata_q <= rd_d;
    end

    AST_SOFT_BLANK: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> (rdata_q == '0)); // R10

endmodule

// File: rtl/wdog_viol_status.sv
module wdog_viol_status
    import wdsts_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_DEF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic              priv,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rdata,
    input  logic              ev_expire,
    input  logic              ev_early_key,
    input  logic              ev_bad_key,
    output logic              nmi_req
);

    logic [NUM_CAUSE-1:0] cause_ev;
    flags_t               flags;

    assign cause_ev = {ev_bad_key, ev_early_key, ev_expire};

    wdsts_flags #(.WORD_W(WORD_W)) u_flags (
        .clk      (clk),
        .por_n    (por_n),
        .wr_en    (wr_en),
        .priv     (priv),
        .wdata    (wdata),
        .cause_ev (cause_ev),
        .flags_q  (flags)
    );

    wdsts_rdport #(.WORD_W(WORD_W)) u_rd (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .rd_en    (rd_en),
        .flags    (flags),
        .rdata_q  (rdata)
    );

    assign nmi_req = flags.summary;

    AST_NMI_DROP: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && priv && wdata[POS_SUM] && !(|cause_ev)) |=> !nmi_req); // R7

    AST_RD_TRACK: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && !soft_rst) |=> ((rdata[POS_SUM] == $past(nmi_req)) &&
                                  (rdata[POS_EXP] == rdata[POS_END]))); // R3

endmodule

// File: tb/sim_wdog_viol_status.sv
module sim_wdog_viol_status;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic        priv = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        ev_expire = 1'b0;
    logic        ev_early_key = 1'b0;
    logic        ev_bad_key = 1'b0;
    logic        nmi_req;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_viol_status u0 (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en), .priv(priv),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .ev_expire(ev_expire),
        .ev_early_key(ev_early_key), .ev_bad_key(ev_bad_key), .nmi_req(nmi_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        {ev_bad_key, ev_early_key, ev_expire} = 3'b000;
    endtask

    task automatic rd(output logic [31:0] v);
        rd_en = 1'b1; tick(); rd_en = 1'b0; v = rdata;
    endtask

    task automatic wr(input logic p, input logic [31:0] d);
        wr_en = 1'b1; priv = p; wdata = d; tick(); idle();
    endtask

    task automatic pulse(input logic [2:0] e);
        {ev_bad_key, ev_early_key, ev_expire} = e; tick(); idle();
    endtask

    // Word layout per R2/R3
    function automatic logic [31:0] expw(input logic s, input logic en, input logic ea, input logic k);
        return (32'(s) << 5) | (32'(en) << 4) | (32'(ea) << 3) | (32'(k) << 2) | (32'(en) << 1);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        tick(); tick(); por_n = 1'b1; tick();

        rd(v);
        check("R1 reset word", v, 32'h0);
        check("R7 reset nmi", 32'(nmi_req), 32'h0);

        // Single cause positions (R2)
        pulse(3'b010); rd(v);
        check("R2 early key position", v, 32'h28);
        wr(1'b1, 32'h20);
        pulse(3'b100); rd(v);
        check("R2 bad key position", v, 32'h24);
        wr(1'b1, 32'h20);
        pulse(3'b001); rd(v);
        check("R2 expiry positions", v, 32'h32);
        wr(1'b1, 32'h02); rd(v);
        check("R3 mirror bit clears expiry", v, 32'h20);
        wr(1'b1, 32'h20);

        // Set everything, unprivileged all-ones write (R5, R1)
        pulse(3'b111);
        wr(1'b0, 32'hFFFF_FFFF); rd(v);
        check("R5 unprivileged write", v, 32'h3E);
        rd(v2);
        check("R10 read has no side effect", v2, v);

        // Soft reset preserves flags, blanks read data (R8, R10)
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        check("R10 soft reset blanks rdata", rdata, 32'h0);
        check("R8 nmi held over soft reset", 32'(nmi_req), 32'h1);
        rd(v);
        check("R8 flags survive soft reset", v, 32'h3E);

        // Power-on reset clears flags
        por_n = 1'b0; tick(); por_n = 1'b1; tick();
        check("R8 por clears rdata", rdata, 32'h0);
        check("R8 por clears nmi", 32'(nmi_req), 32'h0);
        rd(v);
        check("R8 por clears flags", v, 32'h0);

        // Sweep: start state x events x write mask x privilege x reserved fill
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 8; e++) begin
                for (int m = 0; m < 32; m++) begin
                    for (int pv = 0; pv < 2; pv++) begin
                        logic [2:0] pb, eb;
                        logic [4:0] mb;
                        logic s0, s1, en1, ea1, k1, ca, ce, cs, ck;
                        string tg;
                        pb = 3'(p); eb = 3'(e); mb = 5'(m);
                        wr(1'b1, 32'h20);
                        if (pb != 3'b000) pulse(pb);
                        s0 = |pb;
                        wr_en = 1'b1; priv = pv[0];
                        wdata = ((((p + e) % 2) == 1) ? 32'hFFFF_FFC1 : 32'h0) | (32'(mb) << 1);
                        {ev_bad_key, ev_early_key, ev_expire} = eb;
                        tick(); idle();
                        ca = pv[0] & mb[4];
                        ce = pv[0] & (mb[3] | mb[0] | mb[4]);
                        cs = pv[0] & (mb[2] | mb[4]);
                        ck = pv[0] & (mb[1] | mb[4]);
                        en1 = eb[0] | (pb[0] & ~ce);
                        ea1 = eb[1] | (pb[1] & ~cs);
                        k1  = eb[2] | (pb[2] & ~ck);
                        s1  = (|eb) | (s0 & ~ca);
                        if (pv == 0)          tg = "R5 sweep";
                        else if (mb[4])       tg = "R6 sweep";
                        else if (eb != 3'b0)  tg = "R9 sweep";
                        else if (mb == 5'b1)  tg = "R3 sweep";
                        else                  tg = "R4 sweep";
                        check("R7 sweep nmi", 32'(nmi_req), 32'(s1));
                        rd(v);
                        check(tg, v, expw(s1, en1, ea1, k1));
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule